// File: doc/BRIEF.md
# Dual-Output Maskable Interrupt Controller

This block gathers a bank of single-cycle event pulses into sticky flags and routes them to two interrupt pins. Each pin has its own per-flag enable mask, its own global enable and its own output polarity, so one set of events can serve two different handlers. Examples are a fast pin that sees only error events and a slow pin that sees cycle events.

A processor reaches the block through a small synchronous register port. It reads the flags as 16-bit words and clears any flag by writing 1 to its bit. It programs the masks and a control word, and it reads back which outputs are currently asserted. The sources of the events sit outside the block: link distortion, signal loss, cycle timing faults, telegram start and end, timer compare hits, pulse-train and programming faults, and similar.

Register map (word addresses, default parameters): 0 = flags 15:0, 1 = flags 31:16, 2/3 = output 0 mask low/high, 4/5 = output 1 mask low/high, 6 = control, 7 = status.

Top module: `evt_irq_ctrl`

## Requirements
- R1: An event pulse on `evt_i[n]` in cycle c makes flag n read 1 from cycle c+1 on, at bit n%16 of flag word n/16 (address 0 or 1).
- R2: A set flag stays 1 through any number of cycles with no clearing write to its word.
- R3: A write to address 0 or 1 clears every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: If an event pulse and a clearing write hit the same flag in the same cycle, the flag is 1 afterwards.
- R5: Output k is asserted only for flags whose bit in output k's 32-bit mask is 1. The mask for output 0 is at addresses 2 (bits 15:0) and 3 (bits 31:16). The mask for output 1 is at 4 and 5.
- R6: Control word bit 2k is the global enable of output k. While it is 0, output k is inactive whatever the flags.
- R7: Control word bit 2k+1 is the polarity of output k: 0 drives `irq_o[k]` high when active, 1 drives it low when active.
- R8: `irq_active[k]` and status word bit k (address 7) report whether output k is active. Writes to address 7 have no effect.
- R9: Output k's active state is registered: active in cycle c+1 exactly when, in cycle c, enable k was 1 and some flag was 1 with its mask k bit at 1.
- R10: After reset all flags, masks and control bits are 0, both outputs are inactive and both pins are low.
- R11: Masks and control read back as written. Control bits above 2*outputs-1 and status bits above outputs-1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 32 | Single-cycle event pulses, one per flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, combinational |
| irq_o | output | 2 | Interrupt pins after polarity |
| irq_active | output | 2 | Active state of each output, before polarity |

## Verification
A lost or stuck flag bit shows on the flag word read in the cycle after the event or clear. When that bit is enabled, it also shows on `irq_active` one cycle later still. A wrong mask or control register shows at once on readback, and on the pins within two cycles of the next matching event. A polarity fault inverts the pin in the same cycle the polarity changes. The bench therefore compares pins, status and both flag words after every clock, so any divergence is reported in the cycle it first becomes visible.

// File: rtl/evt_irq_pkg.sv
// Package: shared sizes and register layout for the event interrupt controller.
// Assumes the event count is a multiple of the register word width.
package evt_irq_pkg;
    parameter int EVT_N  = 32;   // number of event flags
    parameter int WORD_W = 16;   // register word width
    parameter int OUT_N  = 2;    // number of interrupt outputs

    localparam int NWORDS    = EVT_N / WORD_W;
    localparam int MASK_BASE = NWORDS;
    localparam int CTRL_ADDR = MASK_BASE + OUT_N * NWORDS;
    localparam int STAT_ADDR = CTRL_ADDR + 1;
    localparam int ADDR_W    = $clog2(STAT_ADDR + 1);
endpackage

// File: rtl/evt_flag_bank.sv
// Sticky event flags with write-one-to-clear per register word.
// Assumes events are single-cycle pulses; an event beats a same-cycle clear.
module evt_flag_bank #(
    parameter int EVT_N  = 32,
    parameter int WORD_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [EVT_N-1:0]           evt_i,
    input  logic [EVT_N/WORD_W-1:0]    clr_wr,
    input  logic [WORD_W-1:0]          wdata,
    output logic [EVT_N-1:0]           flag_q
);
    localparam int NWORDS = EVT_N / WORD_W;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [WORD_W-1:0] clr_bits;

        // Purpose: select the clearing bits for this word only when it is addressed.
        always_comb begin
            clr_bits = clr_wr[w] ? wdata : '0;
        end

        // Purpose: hold each flag until cleared; a new event overrides the clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[w*WORD_W +: WORD_W] <= '0;
            end else begin
                flag_q[w*WORD_W +: WORD_W] <= (flag_q[w*WORD_W +: WORD_W] & ~clr_bits)
                                              | evt_i[w*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/irq_lane.sv
// One interrupt output: per-flag mask, global enable, polarity and the
// registered active state. Enable sits at control bit 2*LANE, polarity at 2*LANE+1.
// Assumes WORD_W >= 2*(LANE+1).
module irq_lane #(
    parameter int EVT_N  = 32,
    parameter int WORD_W = 16,
    parameter int LANE   = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [EVT_N-1:0]           flag_q,
    input  logic [EVT_N/WORD_W-1:0]    mask_wr,
    input  logic                       ctrl_wr,
    input  logic [WORD_W-1:0]          wdata,
    output logic [EVT_N-1:0]           mask_q,
    output logic                       en_q,
    output logic                       pol_q,
    output logic                       active_q,
    output logic                       pin_o
);
    localparam int NWORDS  = EVT_N / WORD_W;
    localparam int EN_BIT  = 2 * LANE;
    localparam int POL_BIT = 2 * LANE + 1;

    for (genvar w = 0; w < NWORDS; w++) begin : g_mask
        // Purpose: load one mask word when it is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[w*WORD_W +: WORD_W] <= '0;
            end else if (mask_wr[w]) begin
                mask_q[w*WORD_W +: WORD_W] <= wdata;
            end
        end
    end

    // Purpose: hold the global enable and polarity bits of this lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            pol_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q  <= wdata[EN_BIT];
            pol_q <= wdata[POL_BIT];
        end
    end

    // Purpose: register the enabled OR of masked flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else begin
            active_q <= en_q & (|(flag_q & mask_q));
        end
    end

    // Purpose: apply the output polarity after the register.
    always_comb begin
        pin_o = active_q ^ pol_q;
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
// Top: event flag bank shared by OUT_N interrupt lanes, with a synchronous
// register port (write strobe, combinational read). Synchronous active-low reset.
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int EVT_N  = evt_irq_pkg::EVT_N,
    parameter int WORD_W = evt_irq_pkg::WORD_W,
    parameter int OUT_N  = evt_irq_pkg::OUT_N,
    parameter int ADDR_W = evt_irq_pkg::ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EVT_N-1:0]   evt_i,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic [OUT_N-1:0]   irq_o,
    output logic [OUT_N-1:0]   irq_active
);
    localparam int NW   = EVT_N / WORD_W;
    localparam int MB   = NW;
    localparam int CTRL = MB + OUT_N * NW;
    localparam int STAT = CTRL + 1;

    logic [EVT_N-1:0] flag_q;
    logic [NW-1:0]    clr_wr;
    logic [EVT_N-1:0] lane_mask [OUT_N];
    logic [OUT_N-1:0] lane_en;
    logic [OUT_N-1:0] lane_pol;
    logic             ctrl_wr;

    // Purpose: decode flag-word clearing writes.
    always_comb begin
        for (int w = 0; w < NW; w++) begin
            clr_wr[w] = reg_wr && (reg_addr == ADDR_W'(w));
        end
        ctrl_wr = reg_wr && (reg_addr == ADDR_W'(CTRL));
    end

    evt_flag_bank #(.EVT_N(EVT_N), .WORD_W(WORD_W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .clr_wr (clr_wr),
        .wdata  (reg_wdata),
        .flag_q (flag_q)
    );

    for (genvar k = 0; k < OUT_N; k++) begin : g_lane
        logic [NW-1:0] mask_wr;

        // Purpose: decode the mask-word writes of this lane.
        always_comb begin
            for (int w = 0; w < NW; w++) begin
                mask_wr[w] = reg_wr && (reg_addr == ADDR_W'(MB + k*NW + w));
            end
        end

        irq_lane #(.EVT_N(EVT_N), .WORD_W(WORD_W), .LANE(k)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .flag_q   (flag_q),
            .mask_wr  (mask_wr),
            .ctrl_wr  (ctrl_wr),
            .wdata    (reg_wdata),
            .mask_q   (lane_mask[k]),
            .en_q     (lane_en[k]),
            .pol_q    (lane_pol[k]),
            .active_q (irq_active[k]),
            .pin_o    (irq_o[k])
        );
    end

    // Purpose: combinational read multiplexer over flags, masks, control and status.
    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < NW; w++) begin
            if (reg_addr == ADDR_W'(w)) begin
                reg_rdata = flag_q[w*WORD_W +: WORD_W];
            end
        end
        for (int k = 0; k < OUT_N; k++) begin
            for (int w = 0; w < NW; w++) begin
                if (reg_addr == ADDR_W'(MB + k*NW + w)) begin
                    reg_rdata = lane_mask[k][w*WORD_W +: WORD_W];
                end
            end
        end
        if (reg_addr == ADDR_W'(CTRL)) begin
            for (int k = 0; k < OUT_N; k++) begin
                reg_rdata[2*k]   = lane_en[k];
                reg_rdata[2*k+1] = lane_pol[k];
            end
        end
        if (reg_addr == ADDR_W'(STAT)) begin
            reg_rdata[OUT_N-1:0] = irq_active;
        end
    end
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
// Checker for evt_irq_ctrl: flag set/hold, enable gating and reset state.
// Attached to every instance of the top by the bind below.
module evt_irq_ctrl_chk #(
    parameter int EVT_N  = 32,
    parameter int WORD_W = 16,
    parameter int OUT_N  = 2,
    parameter int ADDR_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [EVT_N-1:0]   evt_i,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [EVT_N-1:0]   flag_q,
    input logic [OUT_N-1:0]   en_q,
    input logic [OUT_N-1:0]   irq_active
);
    localparam int NW = EVT_N / WORD_W;

    logic seen;
    logic clr_any;

    // Purpose: mark cycles whose previous edge was out of reset.
    always_ff @(posedge clk) begin
        seen <= rst_n;
    end

    // Purpose: flag any write that may clear flags.
    always_comb begin
        clr_any = reg_wr && (reg_addr < ADDR_W'(NW));
    end

    // R1 and R4: an event always leaves its flag set, even against a clear.
    p_evt_sets_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> ((flag_q & $past(evt_i)) == $past(evt_i)));

    // R2: without a clearing write no flag drops.
    p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(clr_any)) |-> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R10: reset empties flags and deasserts outputs.
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> ((flag_q == '0) && (irq_active == '0)));

    for (genvar k = 0; k < OUT_N; k++) begin : g_out
        // R6: a disabled lane is inactive in the next cycle.
        p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (seen && !$past(en_q[k])) |-> !irq_active[k]);

        // R9: activity needs a set flag one cycle earlier.
        p_active_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (seen && irq_active[k]) |-> $past(|flag_q));
    end
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
    .EVT_N(EVT_N), .WORD_W(WORD_W), .OUT_N(OUT_N), .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .flag_q     (flag_q),
    .en_q       (lane_en),
    .irq_active (irq_active)
);

// File: tb/evt_irq_ctrl_test.sv
// Bench for evt_irq_ctrl: directed corner cases then seeded random traffic,
// compared every cycle against a bench-side model of the requirements.
module evt_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] evt_i;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic [1:0]  irq_o;
    logic [1:0]  irq_active;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model state
    logic [31:0] m_flag;
    logic [31:0] m_mask [2];
    logic [1:0]  m_en, m_pol, m_act;

    evt_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .irq_active(irq_active)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input int a);
        logic [15:0] r = '0;
        case (a)
            0: r = m_flag[15:0];
            1: r = m_flag[31:16];
            2: r = m_mask[0][15:0];
            3: r = m_mask[0][31:16];
            4: r = m_mask[1][15:0];
            5: r = m_mask[1][31:16];
            6: r = {12'h0, m_pol[1], m_en[1], m_pol[0], m_en[0]};
            default: r = {14'h0, m_act};
        endcase
        return r;
    endfunction

    // One clock with the given stimulus; the model is advanced at the edge.
    task automatic step(input logic [31:0] ev, input logic wr, input int a, input logic [15:0] d);
        logic [1:0] nact;
        @(negedge clk);
        evt_i = ev; reg_wr = wr; reg_addr = 3'(a); reg_wdata = d;
        @(posedge clk);
        for (int k = 0; k < 2; k++) nact[k] = m_en[k] & (|(m_flag & m_mask[k]));
        m_act = nact;
        if (wr) begin
            case (a)
                0: m_flag[15:0]  = m_flag[15:0]  & ~d;
                1: m_flag[31:16] = m_flag[31:16] & ~d;
                2: m_mask[0][15:0]  = d;
                3: m_mask[0][31:16] = d;
                4: m_mask[1][15:0]  = d;
                5: m_mask[1][31:16] = d;
                6: begin m_en = {d[2], d[0]}; m_pol = {d[3], d[1]}; end
                default: ;
            endcase
        end
        m_flag = m_flag | ev;
        #1;
        evt_i = '0; reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input int a);
        reg_addr = 3'(a);
        #1;
        check(req, {16'h0, reg_rdata}, {16'h0, exp_read(a)});
    endtask

    task automatic check_outs(input string req);
        check({req, " irq_active"}, {30'h0, irq_active}, {30'h0, m_act});
        check({req, " irq_o"}, {30'h0, irq_o}, {30'h0, m_act ^ m_pol});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; evt_i = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        m_flag = '0; m_mask[0] = '0; m_mask[1] = '0; m_en = '0; m_pol = '0; m_act = '0;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        for (int a = 0; a < 8; a++) rd("R10 reset read", a);
        check_outs("R10 reset");
        @(negedge clk); rst_n = 1'b1;

        // R1: event sets the flag in its word and bit
        step(32'h0001_0004, 1'b0, 0, 0);
        rd("R1 flag word0", 0); rd("R1 flag word1", 1);
        // R2: sticky through idle cycles
        repeat (5) step(0, 1'b0, 0, 0);
        rd("R2 sticky word0", 0); rd("R2 sticky word1", 1);
        // R3: zero write keeps, one write clears only the chosen bit
        step(0, 1'b1, 0, 16'h0000); rd("R3 zero write", 0);
        step(0, 1'b1, 1, 16'h0001); rd("R3 clear word1", 1); rd("R3 word0 untouched", 0);
        // R4: event and clear on the same flag
        step(32'h0000_0004, 1'b1, 0, 16'h0004); rd("R4 event wins", 0);
        // R5/R11: mask output 1 on flag 2 only, readback
        step(0, 1'b1, 4, 16'h0004); rd("R11 mask readback", 4);
        step(0, 1'b1, 6, 16'hfff4); rd("R11 ctrl unused bits zero", 6);
        check_outs("R9 enable latency");
        step(0, 1'b0, 0, 0);
        check_outs("R5 masked flag drives out1");
        check("R9 out1 active", {31'h0, irq_active[1]}, 32'h1);
        check("R5 out0 unmasked stays off", {31'h0, irq_active[0]}, 32'h0);
        // R7: polarity low-active on out1
        step(0, 1'b1, 6, 16'h000c); check_outs("R7 polarity");
        check("R7 pin low when active", {31'h0, irq_o[1]}, 32'h0);
        // R8: status read and ignored write
        step(0, 1'b1, 7, 16'hffff); rd("R8 status", 7); check_outs("R8 write ignored");
        // R6: disable out1
        step(0, 1'b1, 6, 16'h0008); step(0, 1'b0, 0, 0);
        check_outs("R6 disabled");
        check("R6 out1 off", {31'h0, irq_active[1]}, 32'h0);

        // random traffic
        for (int i = 0; i < 600; i++) begin
            logic [31:0] ev;
            logic        wr;
            int          a;
            ev = (($urandom % 4) == 0) ? (32'h1 << ($urandom % 32)) : '0;
            wr = ($urandom % 3) == 0;
            a  = $urandom % 8;
            step(ev, wr, a, 16'($urandom));
            check_outs("R9 random");
            rd("R1 random flags lo", 0);
            rd("R3 random flags hi", 1);
            rd("R11 random read", $urandom % 8);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule